// File: doc/BRIEF.md
# Adaptive Two-Road Signal Controller

This block drives the lights for two one-way roads that share a crossing. Exactly one road has green at a time. The other road waits through a red phase, and a counter counts that phase down once per clock, where one clock stands for one second. When the countdown runs out, the green road turns red. Both roads then stay red for one clock before the waiting road gets green. At that moment the red time of the road that has just been released is adjusted from its queue length, so a quiet road waits longer next time and a busy road waits less. Every red time is kept inside limits that depend on the road and on whether the current time falls in a busy period.

The controller also keeps a 12-hour time of day. The busy-period flag and a one-clock pulse at the turn of the day are derived from it. A freeze input stops the clock and the countdown together. It is used while an external display borrows the system.

The car counts come from an external queue tracker and are sampled only at handovers.

Top module: `adaptive_signal_ctrl`

## Requirements
- R1: When a road's red phase begins, `red_left` is loaded with that road's stored duration, clamped to the limits that apply under the `rush` value of that clock. The limits are: road A 30–60 in busy time and 40–70 otherwise; road B 40–70 in busy time and 50–80 otherwise.
- R2: On the clock where a road turns green, its stored duration is updated from its car count C, sampled on that clock, and then clamped as in R1. The update is: C ≤ 10 adds 5, C ≥ 20 subtracts 5, and 11–19 keeps the duration.
- R3: While a road is green and `freeze` is low, `red_left` decreases by one on each clock.
- R4: On the clock where `red_left` goes from 1 to 0, the green road turns red and both flags read 0 with `red_left` = 0. On the next unfrozen clock the other road turns green (flag = 1).
- R5: `go_a` and `go_b` are never both 1.
- R6: After reset the outputs show 6:00:00 with `pm` = 0, `go_a` = 1, `go_b` = 0 and `red_left` = 50. The stored durations are 40 for A and 50 for B, and `rush` = 0.
- R7: The time advances one second per unfrozen clock in 12-hour form. Seconds and minutes wrap after 59. Hour 11 goes to 12 and toggles `pm` (1 = PM). Hour 12 goes to 1. Midnight reads 12 with `pm` = 0, and noon reads 12 with `pm` = 1.
- R8: `rush` is 1 exactly from 7:00:00 to 8:59:59 with `pm` = 0 and from 5:00:00 to 6:59:59 with `pm` = 1.
- R9: While `freeze` is 1, the time, `red_left`, the lights and the stored durations do not change.
- R10: `midnight` is 1 for exactly the one clock after the time rolls from 11:59:59 PM to 12:00:00 AM, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per second of simulated time |
| rst | input | 1 | Synchronous reset, active high |
| freeze | input | 1 | Holds time and countdown when 1 |
| cars_a | input | 5 | Cars queued on road A |
| cars_b | input | 5 | Cars queued on road B |
| go_a | output | 1 | 1 = road A green |
| go_b | output | 1 | 1 = road B green |
| red_left | output | 7 | Seconds left on the current red phase |
| hour | output | 4 | Hour, 1 to 12 |
| minute | output | 6 | Minute, 0 to 59 |
| second | output | 6 | Second, 0 to 59 |
| pm | output | 1 | 1 = afternoon half of the day |
| rush | output | 1 | 1 = busy period |
| midnight | output | 1 | One-clock pulse at the start of a new day |

## Verification
The properties assume that reset is held for at least one clock before normal operation. They also assume that `freeze` may take any pattern, so each handover and countdown step is only expected on unfrozen clocks. The car counts are taken to be at most 30, which the 5-bit inputs carry, and to be stable around each rising edge. The stimulus changes every input only on falling edges. It sweeps the counts through the band edges 10, 11, 19 and 20 and inserts short freeze bursts throughout a run from the morning start past midnight.

// File: rtl/sig_pkg.sv
package sig_pkg;
  localparam int ROADS = 2;

  // Phase of the crossing: each road's green phase is followed by an all-red gap
  typedef enum logic [1:0] {
    PH_A_GO    = 2'd0,
    PH_A_CLEAR = 2'd1,
    PH_B_GO    = 2'd2,
    PH_B_CLEAR = 2'd3
  } phase_t;
endpackage

// File: rtl/sig_tod_clock.sv
module sig_tod_clock #(
  parameter int HW            = 4,
  parameter int MW            = 6,
  parameter int START_HOUR    = 6,
  parameter int START_PM      = 0,
  parameter int RUSH_AM_FIRST = 7,
  parameter int RUSH_AM_LAST  = 8,
  parameter int RUSH_PM_FIRST = 5,
  parameter int RUSH_PM_LAST  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [HW-1:0] hour,
  output logic [MW-1:0] minute,
  output logic [MW-1:0] second,
  output logic          pm,
  output logic          rush,
  output logic          midnight
);
  localparam logic [MW-1:0] LAST_SM = MW'(59);
  localparam logic [HW-1:0] NOON_H  = HW'(12);
  localparam logic [HW-1:0] PRE_H   = HW'(11);

  function automatic logic busy(input logic [HW-1:0] h, input logic p);
    if (p) busy = (h >= HW'(RUSH_PM_FIRST)) && (h <= HW'(RUSH_PM_LAST));
    else   busy = (h >= HW'(RUSH_AM_FIRST)) && (h <= HW'(RUSH_AM_LAST));
  endfunction

  logic [HW-1:0] hour_n;
  logic [MW-1:0] min_n, sec_n;
  logic          pm_n, day_wrap;

  // R7: next time of day
  always_comb begin
    sec_n    = second + MW'(1);
    min_n    = minute;
    hour_n   = hour;
    pm_n     = pm;
    day_wrap = 1'b0;
    if (second == LAST_SM) begin
      sec_n = '0;
      min_n = minute + MW'(1);
      if (minute == LAST_SM) begin
        min_n = '0;
        if (hour == PRE_H) begin
          hour_n   = NOON_H;
          pm_n     = ~pm;
          day_wrap = pm;
        end else if (hour == NOON_H) begin
          hour_n = HW'(1);
        end else begin
          hour_n = hour + HW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hour     <= HW'(START_HOUR);
      minute   <= '0;
      second   <= '0;
      pm       <= START_PM[0];
      rush     <= busy(HW'(START_HOUR), START_PM[0]);
      midnight <= 1'b0;
    end else if (tick) begin
      hour     <= hour_n;
      minute   <= min_n;
      second   <= sec_n;
      pm       <= pm_n;
      rush     <= busy(hour_n, pm_n);   // R8
      midnight <= day_wrap;             // R10
    end else begin
      midnight <= 1'b0;
    end
  end
endmodule

// File: rtl/sig_dur_adapt.sv
module sig_dur_adapt #(
  parameter int W        = 7,
  parameter int CW       = 5,
  parameter int RUSH_MIN = 30,
  parameter int RUSH_MAX = 60,
  parameter int REG_MIN  = 40,
  parameter int REG_MAX  = 70,
  parameter int LOW_CNT  = 10,
  parameter int HIGH_CNT = 20,
  parameter int STEP     = 5
) (
  input  logic [W-1:0]  cur,
  input  logic [CW-1:0] cars,
  input  logic          rush,
  output logic [W-1:0]  adapted,
  output logic [W-1:0]  held
);
  logic [W-1:0] lo, hi, stepped;

  function automatic logic [W-1:0] fit(input logic [W-1:0] v,
                                       input logic [W-1:0] a,
                                       input logic [W-1:0] b);
    if (v < a)      fit = a;
    else if (v > b) fit = b;
    else            fit = v;
  endfunction

  always_comb begin
    lo = rush ? W'(RUSH_MIN) : W'(REG_MIN);
    hi = rush ? W'(RUSH_MAX) : W'(REG_MAX);
    // R2: queue-length rule
    if (cars <= CW'(LOW_CNT))       stepped = cur + W'(STEP);
    else if (cars >= CW'(HIGH_CNT)) stepped = cur - W'(STEP);
    else                            stepped = cur;
    adapted = fit(stepped, lo, hi);
    held    = fit(cur, lo, hi);       // R1
  end
endmodule

// File: rtl/sig_phase_seq.sv
module sig_phase_seq
  import sig_pkg::*;
#(
  parameter int W      = 7,
  parameter int A_INIT = 40,
  parameter int B_INIT = 50
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic [ROADS-1:0][W-1:0] adapted,
  input  logic [ROADS-1:0][W-1:0] held,
  output logic                    go_a,
  output logic                    go_b,
  output logic [W-1:0]            red_left,
  output logic [ROADS-1:0][W-1:0] dur
);
  phase_t ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_A_GO;
      red_left <= W'(B_INIT);
      dur[0]   <= W'(A_INIT);
      dur[1]   <= W'(B_INIT);
      go_a     <= 1'b1;
      go_b     <= 1'b0;
    end else if (tick) begin
      case (ph)
        PH_A_GO: begin
          if (red_left == W'(1)) begin      // R4
            ph       <= PH_A_CLEAR;
            red_left <= '0;
            go_a     <= 1'b0;
          end else begin
            red_left <= red_left - W'(1);   // R3
          end
        end
        PH_A_CLEAR: begin
          ph       <= PH_B_GO;
          go_b     <= 1'b1;
          red_left <= held[0];
          dur[1]   <= adapted[1];
        end
        PH_B_GO: begin
          if (red_left == W'(1)) begin
            ph       <= PH_B_CLEAR;
            red_left <= '0;
            go_b     <= 1'b0;
          end else begin
            red_left <= red_left - W'(1);
          end
        end
        default: begin
          ph       <= PH_A_GO;
          go_a     <= 1'b1;
          red_left <= held[1];
          dur[0]   <= adapted[0];
        end
      endcase
    end
  end
endmodule

// File: rtl/adaptive_signal_ctrl.sv
module adaptive_signal_ctrl
  import sig_pkg::*;
#(
  parameter int W          = 7,
  parameter int CW         = 5,
  parameter int HW         = 4,
  parameter int MW         = 6,
  parameter int A_RUSH_MIN = 30,
  parameter int A_RUSH_MAX = 60,
  parameter int A_REG_MIN  = 40,
  parameter int A_REG_MAX  = 70,
  parameter int B_RUSH_MIN = 40,
  parameter int B_RUSH_MAX = 70,
  parameter int B_REG_MIN  = 50,
  parameter int B_REG_MAX  = 80,
  parameter int LOW_CNT    = 10,
  parameter int HIGH_CNT   = 20,
  parameter int STEP       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          freeze,
  input  logic [CW-1:0] cars_a,
  input  logic [CW-1:0] cars_b,
  output logic          go_a,
  output logic          go_b,
  output logic [W-1:0]  red_left,
  output logic [HW-1:0] hour,
  output logic [MW-1:0] minute,
  output logic [MW-1:0] second,
  output logic          pm,
  output logic          rush,
  output logic          midnight
);
  localparam int LIM_RMIN [ROADS] = '{A_RUSH_MIN, B_RUSH_MIN};
  localparam int LIM_RMAX [ROADS] = '{A_RUSH_MAX, B_RUSH_MAX};
  localparam int LIM_GMIN [ROADS] = '{A_REG_MIN,  B_REG_MIN};
  localparam int LIM_GMAX [ROADS] = '{A_REG_MAX,  B_REG_MAX};

  logic                     tick;
  logic [ROADS-1:0][W-1:0]  dur, adapted, held;
  logic [ROADS-1:0][CW-1:0] cnt;

  assign tick = ~freeze;             // R9
  assign cnt  = {cars_b, cars_a};

  sig_tod_clock #(.HW(HW), .MW(MW)) u_tod (
    .clk(clk), .rst(rst), .tick(tick),
    .hour(hour), .minute(minute), .second(second),
    .pm(pm), .rush(rush), .midnight(midnight)
  );

  for (genvar gi = 0; gi < ROADS; gi++) begin : g_road
    sig_dur_adapt #(
      .W(W), .CW(CW),
      .RUSH_MIN(LIM_RMIN[gi]), .RUSH_MAX(LIM_RMAX[gi]),
      .REG_MIN(LIM_GMIN[gi]),  .REG_MAX(LIM_GMAX[gi]),
      .LOW_CNT(LOW_CNT), .HIGH_CNT(HIGH_CNT), .STEP(STEP)
    ) u_adapt (
      .cur(dur[gi]), .cars(cnt[gi]), .rush(rush),
      .adapted(adapted[gi]), .held(held[gi])
    );
  end

  sig_phase_seq #(.W(W), .A_INIT(A_REG_MIN), .B_INIT(B_REG_MIN)) u_seq (
    .clk(clk), .rst(rst), .tick(tick),
    .adapted(adapted), .held(held),
    .go_a(go_a), .go_b(go_b), .red_left(red_left), .dur(dur)
  );
endmodule

// File: rtl/sig_ctrl_checker.sv
module sig_ctrl_checker #(
  parameter int W  = 7,
  parameter int HW = 4,
  parameter int MW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          freeze,
  input logic          go_a,
  input logic          go_b,
  input logic [W-1:0]  red_left,
  input logic [HW-1:0] hour,
  input logic [MW-1:0] minute,
  input logic [MW-1:0] second,
  input logic          pm,
  input logic          midnight
);
  AST_ONE_GREEN: assert property (@(posedge clk) disable iff (rst)
    !(go_a && go_b));                                                        // R5
  AST_GAP_AFTER_A: assert property (@(posedge clk) disable iff (rst)
    (go_a && !freeze && red_left == W'(1)) |=> (!go_a && !go_b && red_left == '0)); // R4
  AST_GAP_AFTER_B: assert property (@(posedge clk) disable iff (rst)
    (go_b && !freeze && red_left == W'(1)) |=> (!go_a && !go_b && red_left == '0)); // R4
  AST_GAP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (!go_a && !go_b && !freeze) |=> (go_a || go_b));                         // R4
  AST_RED_RANGE: assert property (@(posedge clk) disable iff (rst)
    (go_a || go_b) |-> (red_left >= W'(1) && red_left <= W'(80)));          // R1
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    freeze |=> ($stable(second) && $stable(minute) && $stable(red_left) && $stable(go_a) && !midnight)); // R9
  AST_MIDNIGHT_TIME: assert property (@(posedge clk) disable iff (rst)
    midnight |-> (hour == HW'(12) && minute == '0 && second == '0 && !pm));  // R10
  AST_TIME_RANGE: assert property (@(posedge clk) disable iff (rst)
    (second <= MW'(59) && minute <= MW'(59) && hour >= HW'(1) && hour <= HW'(12))); // R7
endmodule

bind adaptive_signal_ctrl sig_ctrl_checker #(.W(W), .HW(HW), .MW(MW)) u_chk (
  .clk(clk), .rst(rst), .freeze(freeze), .go_a(go_a), .go_b(go_b),
  .red_left(red_left), .hour(hour), .minute(minute), .second(second),
  .pm(pm), .midnight(midnight)
);

// File: tb/adaptive_signal_ctrl_test.sv
module adaptive_signal_ctrl_test;
  logic       clk = 1'b0, rst = 1'b1, freeze = 1'b0;
  logic [4:0] cars_a = '0, cars_b = '0;
  logic       go_a, go_b, pm, rush, midnight;
  logic [6:0] red_left;
  logic [3:0] hour;
  logic [5:0] minute, second;

  adaptive_signal_ctrl uut (
    .clk(clk), .rst(rst), .freeze(freeze), .cars_a(cars_a), .cars_b(cars_b),
    .go_a(go_a), .go_b(go_b), .red_left(red_left), .hour(hour),
    .minute(minute), .second(second), .pm(pm), .rush(rush), .midnight(midnight)
  );

  always #10 clk = ~clk;   // 50 MHz

  typedef struct {
    int ga, gb, rem, hr, mn, sc, p, ru, mid;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference state
  int m_ph = 0, m_rem = 50, m_da = 40, m_db = 50;
  int m_hr = 6, m_mn = 0, m_sc = 0, m_pm = 0, m_ru = 0, m_mid = 0;
  bit seen_mid = 0;
  int pat[8] = '{3, 10, 11, 15, 19, 20, 27, 0};

  function automatic int lim(int road, int r, int v);
    int lo, hi;
    if (road == 0) begin lo = r ? 30 : 40; hi = r ? 60 : 70; end
    else           begin lo = r ? 40 : 50; hi = r ? 70 : 80; end
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic int adj(int v, int c);
    return (c <= 10) ? v + 5 : (c >= 20) ? v - 5 : v;
  endfunction

  function automatic int busy(int h, int p);
    return p ? int'(h == 5 || h == 6) : int'(h == 7 || h == 8);
  endfunction

  task automatic chk(string tag, string nm, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, expv);
    end
  endtask

  task automatic model_step();
    int r0;
    if (freeze) begin m_mid = 0; return; end   // R9
    r0 = m_ru;
    case (m_ph)
      0: if (m_rem == 1) begin m_ph = 1; m_rem = 0; end else m_rem--;
      1: begin m_ph = 2; m_db = lim(1, r0, adj(m_db, cars_b)); m_rem = lim(0, r0, m_da); end
      2: if (m_rem == 1) begin m_ph = 3; m_rem = 0; end else m_rem--;
      default: begin m_ph = 0; m_da = lim(0, r0, adj(m_da, cars_a)); m_rem = lim(1, r0, m_db); end
    endcase
    m_mid = 0;
    m_sc++;
    if (m_sc == 60) begin
      m_sc = 0; m_mn++;
      if (m_mn == 60) begin
        m_mn = 0;
        if (m_hr == 11) begin
          m_hr = 12;
          if (m_pm == 1) begin m_mid = 1; seen_mid = 1; end
          m_pm = 1 - m_pm;
        end else if (m_hr == 12) m_hr = 1;
        else m_hr++;
      end
    end
    m_ru = busy(m_hr, m_pm);
  endtask

  task automatic push_expected();
    exp_t e;
    e.ga = (m_ph == 0); e.gb = (m_ph == 2); e.rem = m_rem;
    e.hr = m_hr; e.mn = m_mn; e.sc = m_sc; e.p = m_pm; e.ru = m_ru; e.mid = m_mid;
    exp_q.push_back(e);
  endtask

  // driver
  initial begin
    repeat (3) @(negedge clk);
    chk("R6", "go_a", int'(go_a), 1);
    chk("R6", "go_b", int'(go_b), 0);
    chk("R6", "red_left", int'(red_left), 50);
    chk("R6", "hour", int'(hour), 6);
    chk("R6", "minute", int'(minute), 0);
    chk("R6", "second", int'(second), 0);
    chk("R6", "pm", int'(pm), 0);
    chk("R6", "rush", int'(rush), 0);
    chk("R10", "midnight", int'(midnight), 0);
    for (int cyc = 0; cyc < 80000 && !(seen_mid && m_mn >= 10); cyc++) begin
      rst    = 1'b0;
      freeze = ((cyc % 211) < 4);
      cars_a = 5'(pat[(cyc / 53) % 8]);
      cars_b = 5'(pat[((cyc / 71) + 3) % 8]);
      model_step();
      push_expected();
      @(negedge clk);
    end
    freeze = 1'b1;
    wait (exp_q.size() == 0);
    #5;
    chk("R10", "midnight seen", int'(seen_mid), 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R4", "go_a", int'(go_a), e.ga);
        chk("R4", "go_b", int'(go_b), e.gb);
        chk("R5", "both green", int'(go_a & go_b), 0);
        chk("R1 R2 R3", "red_left", int'(red_left), e.rem);
        chk("R7", "hour", int'(hour), e.hr);
        chk("R7", "minute", int'(minute), e.mn);
        chk("R7 R9", "second", int'(second), e.sc);
        chk("R7", "pm", int'(pm), e.p);
        chk("R8", "rush", int'(rush), e.ru);
        chk("R10", "midnight", int'(midnight), e.mid);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule